// File: doc/BRIEF.md
# Reset Cause and Watchdog Flag Register Block

This block keeps a sticky record of which reset detectors have fired since software last looked, and owns the watchdog control byte together with its time-out interrupt flag. Each reset detector (power-on, brown-out, external pin, watchdog) drives a one-cycle event pulse. The block turns these pulses into flags that stay set until software clears them. Software clears a reset flag by writing a zero to its bit. A power-on event also clears every cause flag except its own.

The watchdog control byte holds an interrupt enable, a system-reset enable and four prescaler select bits. The prescaler bits are only stored here, for a counter elsewhere to use. When the watchdog counter reports a time-out, the block does one of two things, decided by the two enables. In interrupt mode it sets a time-out flag. That flag, the interrupt enable and the global interrupt bit together raise an interrupt request. When the reset enable is set, the block instead issues a one-cycle system-reset request and marks the watchdog as the cause. The time-out flag clears when the CPU acknowledges the interrupt, or when software writes a one to it.

Both bytes are always visible on output ports. A single write strobe with a select bit updates one of them.

Top module: `rst_cause_wdt_regs`

## Requirements
- R1: After the synchronous reset `rst`, both bytes read 0x00, and `irq`, `wdt_rst_req` and `irq_mode` are 0.
- R2: In the cause byte, bit 0 is power-on, bit 1 is external, bit 2 is brown-out and bit 3 is watchdog. Bits 7..4 read 0. An event pulse sets its own bit on the next clock.
- R3: A power-on event sets bit 0 and clears bits 3..1 of the cause byte. It never clears bit 0.
- R4: A write to the cause byte (`reg_sel`=0) clears each bit 3..0 whose written value is 0. Bits written with 1 keep their value.
- R5: When a set event and a clearing write or power-on clear hit the same flag in one cycle, the flag ends up set.
- R6: In the control byte, bits 6 (interrupt enable), 3 (reset enable) and 5, 2, 1, 0 (prescaler) are plain read/write bits. Bit 4 always reads 0.
- R7: A time-out sets control bit 7 only when bit 6 is 1 and bit 3 is 0 (interrupt mode).
- R8: Control bit 7 clears on `irq_ack` or on a control write with bit 7 = 1. A written 0 leaves it unchanged. A time-out in interrupt mode in the same cycle wins over either clear.
- R9: `irq` is registered and equals control bit 7 AND bit 6 AND `gie`, where `gie` is the value sampled at the same edge.
- R10: A time-out with control bit 3 = 1 gives a one-cycle `wdt_rst_req` on the next clock and sets cause bit 3. A `wdt_rst_evt` pulse also sets cause bit 3.
- R11: `irq_mode` is 1 exactly when control bit 6 = 1 and bit 3 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt | input | 1 | Power-on reset event pulse |
| bor_evt | input | 1 | Brown-out reset event pulse |
| ext_evt | input | 1 | External reset event pulse |
| wdt_rst_evt | input | 1 | Watchdog reset event pulse |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| irq_ack | input | 1 | Interrupt vector taken strobe |
| gie | input | 1 | Global interrupt enable |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = cause byte, 1 = control byte |
| reg_wdata | input | 8 | Write data |
| cause_byte | output | 8 | Reset cause byte |
| wdt_ctrl | output | 8 | Watchdog control byte |
| irq | output | 1 | Watchdog interrupt request |
| wdt_rst_req | output | 1 | One-cycle system-reset request |
| irq_mode | output | 1 | 1 = a time-out raises an interrupt, 0 = it does not |

## Verification
Every flag is a visible register bit, so a wrong internal state shows on `cause_byte` or `wdt_ctrl` one clock after the event that caused it. A wrong mode decision shows in the same cycle on `irq_mode`. On the following clock it also shows as a missing or extra `wdt_rst_req` or time-out flag. The bench's reference model is compared against all five outputs on every cycle. It covers the collision cycles where set and clear meet, so a wrong priority is caught within one clock.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int BYTE_W    = 8;
  localparam int N_CAUSE   = 4;
  // cause byte bit positions
  localparam int C_POR     = 0;
  localparam int C_EXT     = 1;
  localparam int C_BOR     = 2;
  localparam int C_WDT     = 3;
  // control byte bit positions
  localparam int K_FLAG    = 7;
  localparam int K_IE      = 6;
  localparam int K_RE      = 3;
  // plain read/write bits of the control byte (6,5,3,2,1,0)
  localparam logic [BYTE_W-1:0] K_RW_MASK = 8'b0110_1111;
  typedef enum logic {SEL_CAUSE = 1'b0, SEL_CTRL = 1'b1} reg_sel_e;
endpackage

// File: rtl/rcu_cause_flags.sv
module rcu_cause_flags
  import rcu_pkg::*;
#(
  parameter int N_SRC   = N_CAUSE,
  parameter int POR_IDX = C_POR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_evt,
  input  logic             por_evt,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_bits,
  output logic [N_SRC-1:0] flags_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    localparam bit IS_POR = (i == POR_IDX);
    logic clr;
    assign clr = (wr_en & ~wr_bits[i]) | (por_evt & !IS_POR);

    always_ff @(posedge clk) begin
      if (rst)             flags_q[i] <= 1'b0;
      else if (set_evt[i]) flags_q[i] <= 1'b1;
      else if (clr)        flags_q[i] <= 1'b0;
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flags_q[i]);
    p_one_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_bits[i] && !set_evt[i] && !(por_evt && !IS_POR))
        |=> flags_q[i] == $past(flags_q[i]));
  end
endmodule

// File: rtl/rcu_wdt_ctl.sv
module rcu_wdt_ctl
  import rcu_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         tmo,
  input  logic         irq_ack,
  input  logic         gie,
  output logic [W-1:0] ctl_q,
  output logic         irq_q,
  output logic         rst_req_q,
  output logic         irq_mode
);
  logic         flag_set, flag_clr, flag_n;
  logic [W-1:0] ctl_n;

  assign irq_mode = ctl_q[K_IE] & ~ctl_q[K_RE];
  assign flag_set = tmo & irq_mode;
  assign flag_clr = irq_ack | (wr_en & wr_data[K_FLAG]);

  always_comb begin
    flag_n = ctl_q[K_FLAG];
    if (flag_clr) flag_n = 1'b0;
    if (flag_set) flag_n = 1'b1;
    ctl_n = wr_en ? (wr_data & K_RW_MASK) : (ctl_q & K_RW_MASK);
    ctl_n[K_FLAG] = flag_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      ctl_q     <= ctl_n;
      irq_q     <= flag_n & ctl_n[K_IE] & gie;
      rst_req_q <= tmo & ctl_q[K_RE];
    end
  end

  p_tmo_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (tmo && ctl_q[K_IE] && !ctl_q[K_RE]) |=> ctl_q[K_FLAG]);
  p_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[K_FLAG] && !(ctl_q[K_IE] && !ctl_q[K_RE])) |=> !ctl_q[K_FLAG]);
  p_ack_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !tmo) |=> !ctl_q[K_FLAG]);
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ctl_q[K_FLAG] && ctl_q[K_IE]));
  p_mode_r11: assert property (@(posedge clk) disable iff (rst)
    irq_mode |-> !rst_req_q || $past(!ctl_q[K_IE] || ctl_q[K_RE]) || $past(rst));
endmodule

// File: rtl/rst_cause_wdt_regs.sv
module rst_cause_wdt_regs
  import rcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       por_evt,
  input  logic       bor_evt,
  input  logic       ext_evt,
  input  logic       wdt_rst_evt,
  input  logic       wdt_timeout,
  input  logic       irq_ack,
  input  logic       gie,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] cause_byte,
  output logic [7:0] wdt_ctrl,
  output logic       irq,
  output logic       wdt_rst_req,
  output logic       irq_mode
);
  localparam int PAD_W = BYTE_W - N_CAUSE;

  logic [N_CAUSE-1:0] set_vec, flags;
  logic               we_cause, we_ctrl, wd_set;

  assign we_cause = reg_we & (reg_sel_e'(reg_sel) == SEL_CAUSE);
  assign we_ctrl  = reg_we & (reg_sel_e'(reg_sel) == SEL_CTRL);
  assign wd_set   = wdt_rst_evt | (wdt_timeout & wdt_ctrl[K_RE]);

  always_comb begin
    set_vec        = '0;
    set_vec[C_POR] = por_evt;
    set_vec[C_EXT] = ext_evt;
    set_vec[C_BOR] = bor_evt;
    set_vec[C_WDT] = wd_set;
  end

  rcu_cause_flags #(.N_SRC(N_CAUSE), .POR_IDX(C_POR)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_vec),
    .por_evt (por_evt),
    .wr_en   (we_cause),
    .wr_bits (reg_wdata[N_CAUSE-1:0]),
    .flags_q (flags)
  );

  rcu_wdt_ctl #(.W(BYTE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (we_ctrl),
    .wr_data   (reg_wdata),
    .tmo       (wdt_timeout),
    .irq_ack   (irq_ack),
    .gie       (gie),
    .ctl_q     (wdt_ctrl),
    .irq_q     (irq),
    .rst_req_q (wdt_rst_req),
    .irq_mode  (irq_mode)
  );

  assign cause_byte = {{PAD_W{1'b0}}, flags};

  p_wdt_reset_r10: assert property (@(posedge clk) disable iff (rst)
    (wdt_timeout && wdt_ctrl[K_RE]) |=> (wdt_rst_req && cause_byte[C_WDT]));
  p_por_sets_r3: assert property (@(posedge clk) disable iff (rst)
    por_evt |=> cause_byte[C_POR]);
  p_req_cause_r10: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_req |-> cause_byte[C_WDT] || $past(reg_we && !reg_sel));
endmodule

// File: tb/rst_cause_wdt_regs_bench.sv
`timescale 1ns/1ps
module rst_cause_wdt_regs_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_evt = 0, bor_evt = 0, ext_evt = 0, wdt_rst_evt = 0;
  logic wdt_timeout = 0, irq_ack = 0, gie = 0, reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] cause_byte, wdt_ctrl;
  logic irq, wdt_rst_req, irq_mode;

  always #5 clk = ~clk;

  rst_cause_wdt_regs u_rst_cause_wdt_regs (
    .clk(clk), .rst(rst), .por_evt(por_evt), .bor_evt(bor_evt), .ext_evt(ext_evt),
    .wdt_rst_evt(wdt_rst_evt), .wdt_timeout(wdt_timeout), .irq_ack(irq_ack), .gie(gie),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cause_byte(cause_byte), .wdt_ctrl(wdt_ctrl), .irq(irq),
    .wdt_rst_req(wdt_rst_req), .irq_mode(irq_mode));

  int n_chk = 0, n_fail = 0;
  string tag = "R1 reset";
  bit started = 0;

  // reference model state
  bit m_wdr, m_bor, m_ext, m_por, m_flag, m_ie, m_re, m_irq, m_req;
  bit [3:0] m_pre; // prescaler bits stored as {b5,b2,b1,b0}

  function automatic [7:0] exp_cause();
    return {4'h0, m_wdr, m_bor, m_ext, m_por};
  endfunction
  function automatic [7:0] exp_ctrl();
    return {m_flag, m_ie, m_pre[3], 1'b0, m_re, m_pre[2:0]};
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      {m_wdr, m_bor, m_ext, m_por, m_flag, m_ie, m_re, m_irq, m_req} = '0;
      m_pre = '0;
    end else begin
      bit tmo_irq, tmo_rst;
      tmo_irq = wdt_timeout && m_ie && !m_re;
      tmo_rst = wdt_timeout && m_re;
      if (reg_we && !reg_sel) begin
        if (!reg_wdata[3]) m_wdr = 0;
        if (!reg_wdata[2]) m_bor = 0;
        if (!reg_wdata[1]) m_ext = 0;
        if (!reg_wdata[0]) m_por = 0;
      end
      if (por_evt) begin m_wdr = 0; m_bor = 0; m_ext = 0; m_por = 1; end
      if (bor_evt) m_bor = 1;
      if (ext_evt) m_ext = 1;
      if (wdt_rst_evt || tmo_rst) m_wdr = 1;
      if (irq_ack || (reg_we && reg_sel && reg_wdata[7])) m_flag = 0;
      if (tmo_irq) m_flag = 1;
      if (reg_we && reg_sel) begin
        m_ie  = reg_wdata[6];
        m_re  = reg_wdata[3];
        m_pre = {reg_wdata[5], reg_wdata[2:0]};
      end
      m_req = tmo_rst;
      m_irq = m_flag && m_ie && gie;
    end
  end

  task automatic chk8(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk8("cause_byte", cause_byte, exp_cause());
    chk8("wdt_ctrl", wdt_ctrl, exp_ctrl());
    chk8("irq", {7'd0, irq}, {7'd0, m_irq});
    chk8("wdt_rst_req", {7'd0, wdt_rst_req}, {7'd0, m_req});
    chk8("irq_mode", {7'd0, irq_mode}, {7'd0, (m_ie && !m_re)});
  end

  task automatic cyc();
    @(negedge clk);
    {por_evt, bor_evt, ext_evt, wdt_rst_evt, wdt_timeout, irq_ack, reg_we} = '0;
    reg_wdata = 8'h00;
  endtask
  task automatic wr(bit sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    tag = "R1 reset state"; cyc(); cyc();
    tag = "R2 event sets own bit";
    ext_evt = 1; cyc(); bor_evt = 1; cyc(); wdt_rst_evt = 1; cyc(); cyc();
    tag = "R4 write ones keep, zeros clear";
    wr(0, 8'hFF); wr(0, 8'hF5); cyc();
    tag = "R3 power-on clears others keeps own";
    bor_evt = 1; ext_evt = 1; cyc(); por_evt = 1; cyc(); por_evt = 1; cyc(); cyc();
    tag = "R5 set beats clear";
    bor_evt = 1; reg_we = 1; reg_sel = 0; reg_wdata = 8'h00; cyc();
    por_evt = 1; ext_evt = 1; cyc(); wr(0, 8'h00); cyc();
    tag = "R6 control rw bits";
    wr(1, 8'h7F); cyc(); wr(1, 8'h10); wr(1, 8'h00); cyc();
    tag = "R11 mode select";
    wr(1, 8'h40); wr(1, 8'h48); wr(1, 8'h08); wr(1, 8'h00); cyc();
    tag = "R7 timeout outside irq mode";
    wdt_timeout = 1; cyc(); wr(1, 8'h48); wdt_timeout = 1; cyc(); cyc();
    tag = "R10 reset request";
    wdt_timeout = 1; cyc(); cyc(); wr(0, 8'h00); wdt_rst_evt = 1; cyc(); wr(1, 8'h00);
    tag = "R7 timeout in irq mode";
    wr(1, 8'h40); wdt_timeout = 1; cyc(); cyc();
    tag = "R9 irq gated by gie";
    gie = 1; cyc(); cyc(); gie = 0; cyc(); gie = 1; cyc();
    tag = "R8 clears";
    wr(1, 8'h40); cyc(); wr(1, 8'hC0); cyc();
    wdt_timeout = 1; cyc(); irq_ack = 1; cyc(); cyc();
    wdt_timeout = 1; irq_ack = 1; cyc(); cyc();
    wdt_timeout = 1; reg_we = 1; reg_sel = 1; reg_wdata = 8'hC0; cyc(); cyc();
    tag = "R2 R5 R8 R10 mixed stimulus";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      por_evt = (r[3:0] == 0); bor_evt = (r[7:4] == 0); ext_evt = (r[11:8] == 0);
      wdt_rst_evt = (r[15:12] == 0); wdt_timeout = r[16] & r[17];
      irq_ack = (r[20:18] == 0); gie = r[21];
      reg_we = (r[24:22] == 0); reg_sel = r[25]; reg_wdata = $urandom;
      cyc();
    end
    tag = "R1 reset again";
    rst = 1; cyc(); rst = 0; cyc(); cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule